// File: doc/BRIEF.md
# Shared March Self-Test Engine for Four Word Memories

This block runs a March C- self-test over four small embedded SRAMs that hold 16-bit words. Two of them hold 32 words and two hold 256 words. A single sequencer, operation timer and address counter are time-shared: the memories are tested one after another, and the counter's terminal value is reloaded whenever the next memory is selected. Each read and write covers a whole word. The two data backgrounds are all zeros and all ones.

A one-cycle `start` pulse launches a run. The engine drives one shared address and write-data bus. It gives each memory its own chip-enable and write-enable, and returns read data on a concatenated bus. Each memory has a sticky fail flag and a done flag. A global `done` and `pass` summarise the run. The element sequence is: any-order write 0; ascending read 0 / write 1; ascending read 1 / write 0; descending read 0 / write 1; descending read 1 / write 0; any-order read 0. Any-order elements run ascending. That makes 10 operations per word, one operation per clock.

Top module: `mbist_shared`

## Requirements
- R1: A `start` pulse while idle begins a run at memory 0. A `start` seen while a run is in progress, or in the cycle its final compare is pending, has no effect on the operation sequence.
- R2: Memories are tested in the order 0, 1, 2, 3. During a run exactly one bit of `mem_ce` is high, bit i selecting memory i, and `mem_we` is high only on that same bit.
- R3: The address runs over 0..31 for memories 0 and 1 and over 0..255 for memories 2 and 3.
- R4: For each memory the operations follow the six March C- elements in the order listed, with ascending elements counting the address up from 0 and descending elements counting it down from the top address.
- R5: Writes of background 0 drive `mem_wdata` = 16'h0000 and writes of background 1 drive 16'hFFFF. Reads expect the same values.
- R6: One operation is issued per clock, so memory i occupies exactly 10 x depth consecutive cycles. The next memory starts on the cycle after.
- R7: The read data for memory i sits at `mem_rdata[16*i +: 16]` and is sampled on the clock after the read was issued. Any mismatch sets `mem_fail[i]`, which stays set until the next run starts.
- R8: `mem_done[i]` rises two cycles after the last operation of memory i is presented. `done` equals `mem_done[3]` and holds until a new run starts.
- R9: `pass` is high only when `done` is high and all four fail flags are clear.
- R10: Starting a new run clears all fail and done flags. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request pulse |
| mem_rdata | input | 64 | Read data, memory i in bits 16*i+15..16*i |
| mem_ce | output | 4 | Per-memory chip enable |
| mem_we | output | 4 | Per-memory write enable |
| mem_addr | output | 8 | Shared word address |
| mem_wdata | output | 16 | Shared write data |
| mem_fail | output | 4 | Sticky per-memory fail flags |
| mem_done | output | 4 | Per-memory test complete |
| done | output | 1 | Whole run complete |
| pass | output | 1 | Run complete with no failure |

## Verification
The bench drives the engine against fault-free memories and checks every issued operation against an independently built list of March operations. This separates a correct element order, direction and background from swapped or mis-bounded ones. A single stuck-at-0 bit inside a 32-word memory shows that failures are attributed to the correct memory and nowhere else. A stuck-at-1 bit on the top address of memory 0, combined with an address alias in memory 3, probes the counter's terminal value and March C-'s address-fault coverage. A stray start pulse mid-run shows that a busy engine ignores new requests.

// File: rtl/mbist_shared.sv
module mbist_shared #(
  parameter int DW   = 16,
  parameter int AW_S = 5,
  parameter int AW_L = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [4*DW-1:0]   mem_rdata,
  output logic [3:0]        mem_ce,
  output logic [3:0]        mem_we,
  output logic [AW_L-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [3:0]        mem_fail,
  output logic [3:0]        mem_done,
  output logic              done,
  output logic              pass
);
  localparam logic [AW_L-1:0] LIM_S = AW_L'((1 << AW_S) - 1);
  localparam logic [AW_L-1:0] LIM_L = AW_L'((1 << AW_L) - 1);

  logic            running, op, rd_pend, rd_exp, rd_last;
  logic [1:0]      sel, rd_sel;
  logic [2:0]      elem;
  logic [AW_L-1:0] addr, limit;
  logic            single, last_op, is_read, down, at_end, nxt_down;

  assign limit    = sel[1] ? LIM_L : LIM_S;
  assign single   = (elem == 3'd0) || (elem == 3'd5);
  assign last_op  = single || op;
  assign is_read  = (elem == 3'd5) || ((elem != 3'd0) && !op);
  assign down     = (elem == 3'd3) || (elem == 3'd4);
  assign nxt_down = (elem == 3'd2) || (elem == 3'd3);
  assign at_end   = down ? (addr == '0) : (addr == limit);

  assign mem_ce    = running ? (4'd1 << sel) : 4'd0;
  assign mem_we    = mem_ce & {4{~is_read}};
  assign mem_addr  = addr;
  assign mem_wdata = {DW{elem[0]}};
  assign done      = mem_done[3];
  assign pass      = done & ~|mem_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      op       <= 1'b0;
      sel      <= '0;
      elem     <= '0;
      addr     <= '0;
      rd_pend  <= 1'b0;
      rd_exp   <= 1'b0;
      rd_sel   <= '0;
      rd_last  <= 1'b0;
      mem_fail <= '0;
      mem_done <= '0;
    end else begin
      rd_pend <= running && is_read;
      rd_exp  <= (elem == 3'd2) || (elem == 3'd4);
      rd_sel  <= sel;
      rd_last <= (elem == 3'd5) && at_end;
      if (rd_pend) begin
        if (mem_rdata[rd_sel*DW +: DW] != {DW{rd_exp}}) mem_fail[rd_sel] <= 1'b1;
        if (rd_last) mem_done[rd_sel] <= 1'b1;
      end
      if (!running) begin
        if (start && !rd_pend) begin
          running  <= 1'b1;
          sel      <= '0;
          elem     <= '0;
          op       <= 1'b0;
          addr     <= '0;
          mem_fail <= '0;
          mem_done <= '0;
        end
      end else if (!last_op) begin
        op <= 1'b1;
      end else begin
        op <= 1'b0;
        if (!at_end) begin
          addr <= down ? addr - 1'b1 : addr + 1'b1;
        end else if (elem != 3'd5) begin
          elem <= elem + 3'd1;
          addr <= nxt_down ? limit : '0;
        end else begin
          elem <= '0;
          addr <= '0;
          if (sel == 2'd3) running <= 1'b0;
          else sel <= sel + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/mbist_shared_chk.sv
module mbist_shared_chk #(
  parameter int DW   = 16,
  parameter int AW_S = 5,
  parameter int AW_L = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [4*DW-1:0]   mem_rdata,
  input logic [3:0]        mem_ce,
  input logic [3:0]        mem_we,
  input logic [AW_L-1:0]   mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic [3:0]        mem_fail,
  input logic [3:0]        mem_done,
  input logic              done,
  input logic              pass
);
  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mem_ce));
  // R2
  we_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) (mem_we & ~mem_ce) == 4'd0);
  // R3
  small_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_ce[1:0]) |-> (mem_addr <= AW_L'((1 << AW_S) - 1)));
  // R5
  bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> (mem_wdata == '0 || mem_wdata == '1));
  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_ce) |=> ((mem_fail & $past(mem_fail)) == $past(mem_fail)));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done);
  // R9
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n) pass |-> (done && mem_fail == 4'd0));
endmodule

bind mbist_shared mbist_shared_chk #(.DW(DW), .AW_S(AW_S), .AW_L(AW_L)) chk (.*);

// File: tb/mbist_shared_test.sv
module mbist_shared_test;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] mem_rdata;
  logic [3:0]  mem_ce, mem_we, mem_fail, mem_done;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        done, pass;

  always #5 clk = ~clk;

  mbist_shared uut (.*);

  typedef struct { int m; bit we; int addr; logic [15:0] d; bit last; } op_t;
  op_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [15:0] marr [4][256];
  logic [15:0] rd [4];
  bit sa_on = 0, al_on = 0;
  int sa_m, sa_a, sa_b, al_m, al_src, al_dst;
  logic sa_v;
  assign mem_rdata = {rd[3], rd[2], rd[1], rd[0]};

  initial begin
    for (int i = 0; i < 4; i++) begin
      rd[i] = '0;
      for (int a = 0; a < 256; a++) marr[i][a] = '0;
    end
  end

  always @(posedge clk) begin
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      if (mem_ce[i]) begin
        if (mem_we[i]) begin
          marr[i][mem_addr] <= mem_wdata;
          if (al_on && i == al_m && int'(mem_addr) == al_src) marr[i][al_dst] <= mem_wdata;
        end else begin
          v = marr[i][mem_addr];
          if (sa_on && i == sa_m && int'(mem_addr) == sa_a) v[sa_b] = sa_v;
          rd[i] <= v;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input int m, input bit we, input int a, input logic [15:0] d, input bit last);
    op_t o;
    o.m = m; o.we = we; o.addr = a; o.d = d; o.last = last;
    q.push_back(o);
  endtask

  task automatic build();
    q.delete();
    for (int m = 0; m < 4; m++) begin
      int n = (m < 2) ? 32 : 256;
      for (int a = 0; a < n; a++) push(m, 1, a, 16'h0000, 0);
      for (int a = 0; a < n; a++) begin push(m, 0, a, 16'h0000, 0); push(m, 1, a, 16'hFFFF, 0); end
      for (int a = 0; a < n; a++) begin push(m, 0, a, 16'hFFFF, 0); push(m, 1, a, 16'h0000, 0); end
      for (int a = n-1; a >= 0; a--) begin push(m, 0, a, 16'h0000, 0); push(m, 1, a, 16'hFFFF, 0); end
      for (int a = n-1; a >= 0; a--) begin push(m, 0, a, 16'hFFFF, 0); push(m, 1, a, 16'h0000, 0); end
      for (int a = 0; a < n; a++) push(m, 0, a, 16'h0000, a == n-1);
    end
  endtask

  task automatic run(input logic [3:0] exp_fail, input bit poke);
    logic [3:0] exp_done = 4'd0, st1 = 4'd0, st2 = 4'd0;
    int idx = 0;
    build();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R10: flags cleared once the new run is under way
    check(mem_fail == 0 && mem_done == 0 && !done, "R10", {mem_fail, mem_done}, 0);
    while (q.size() > 0) begin
      op_t o = q.pop_front();
      exp_done |= st2; st2 = st1; st1 = 4'd0;
      // R1 R2 R3 R4 R6: one operation per cycle, in reference order
      check(mem_ce == (4'd1 << o.m) && mem_we == (o.we ? (4'd1 << o.m) : 4'd0) && int'(mem_addr) == o.addr,
            "R4", {mem_ce, mem_we, 8'd0, mem_addr}, {4'd1 << o.m, o.we ? 4'd1 << o.m : 4'd0, 8'd0, 8'(o.addr)});
      // R5
      if (o.we) check(mem_wdata == o.d, "R5", mem_wdata, o.d);
      // R8
      check(mem_done == exp_done, "R8", mem_done, exp_done);
      if (o.last) st1 = 4'd1 << o.m;
      idx++;
      start = (poke && idx == 700);
      @(negedge clk);
    end
    start = 1'b0;
    exp_done |= st2; st2 = st1;
    // R6: sequence ends exactly after 10n cycles per memory
    check(mem_ce == 0 && !done && mem_done == exp_done, "R6", {mem_ce, mem_done}, {4'd0, exp_done});
    @(negedge clk);
    exp_done |= st2;
    // R8
    check(done && mem_done == 4'hF, "R8", {done, mem_done}, 5'h1F);
    // R7
    check(mem_fail == exp_fail, "R7", mem_fail, exp_fail);
    // R9
    check(pass == (exp_fail == 0), "R9", pass, exp_fail == 0);
    repeat (3) @(negedge clk);
    // R8: done held while idle
    check(done && pass == (exp_fail == 0), "R8", {done, pass}, {1'b1, exp_fail == 0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(mem_ce == 0 && mem_we == 0 && mem_fail == 0 && mem_done == 0 && !done && !pass,
          "R10", {mem_ce, mem_we, mem_fail, mem_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: fault-free run with a stray start mid-run
    run(4'b0000, 1);
    // R7: stuck-at-0 bit 3 at word 17 of memory 1
    sa_on = 1; sa_m = 1; sa_a = 17; sa_b = 3; sa_v = 1'b0;
    run(4'b0010, 0);
    // R3 R7: stuck-at-1 at top word of memory 0, alias 200->201 in memory 3
    sa_m = 0; sa_a = 31; sa_b = 15; sa_v = 1'b1;
    al_on = 1; al_m = 3; al_src = 200; al_dst = 201;
    run(4'b1001, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule